// File: doc/BRIEF.md
# Two-Wire Debug Register Read Slave

This block is the target side of a two-wire debug port. An external master owns the debug clock line. Both sides share a data line, which is modelled as a wired-AND. A transaction opens with a start condition. The master then sends a header that holds a 7-bit register address and a direction bit. For a read, the slave shifts out the addressed status register one byte at a time. Each unit on the line, header or data, is closed by one separator bit that the master drives. A separator of 1 asks for the next register in the same transaction. A separator of 0 ends the transfer.

Both debug lines are brought into the system clock domain through a two-flop synchronizer before any edge is detected. The slave latches the data line on the rising debug-clock edge. It changes its own output only after a falling edge. Toward the chip, the block presents a register address and takes back the register contents on a plain parallel bus. That bus is combinational: the register source must return the byte in the same system cycle. There is therefore no valid/ready handshake and no back-pressure. The master's pace on the debug clock is the only flow control.

Top module: `dbg_rd_slave`

## Requirements
- R1: The header is 8 bits, latched on rising debug-clock edges: the register address with its most significant bit first, then a direction bit where 1 means read.
- R2: A separator bit follows the header and every data byte, so each unit spans 9 debug-clock periods. The slave keeps its output enable low during the header and during every separator.
- R3: For a read, the slave drives each data byte most significant bit first, taken from the register at the current address. The output enable and output value change only after a falling debug-clock edge. The output value stays unchanged while the debug clock is high.
- R4: A separator of 1 after a data byte advances the address by one. The next register then follows without a new header.
- R5: The address counter stops at 0x1F. Once it holds 0x1F or higher, further bytes return the same register.
- R6: A separator of 0 after a data byte ends the transfer. Further debug-clock activity causes no drive until the next start condition.
- R7: A start condition is a falling data line while the debug clock is high. It returns the slave to the first header bit from any state, including in the middle of a header or at a data separator.
- R8: A header with direction bit 0 (write) never causes the slave to drive the data line.
- R9: During reset, the output enable is low and the register address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_clk_i | input | 1 | Debug clock from the master (asynchronous) |
| dbg_dat_i | input | 1 | Sensed level of the shared data line |
| dbg_dat_o | output | 1 | Value the slave places on the data line |
| dbg_dat_oe | output | 1 | Output enable for the data line |
| reg_addr_o | output | 7 | Address of the register being read |
| reg_data_i | input | 8 | Contents of the addressed register, returned in the same cycle |

## Verification
Several properties are checked on every system cycle. The output enable may rise only after a detected falling debug-clock edge. The output value must hold while the debug clock is high. The enable must stay low through the header. A start must put the slave at header bit zero. Every address change must be a single step from below the ceiling, and the counter must hold at the ceiling. The bench scenarios cover the rest: the header framing, the byte order and contents across long blocks, saturation seen at the line, the end of a transfer, write headers that stay silent, and restarts in the middle of a header or at a separator.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } dbg_phase_t;
endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_V}};
    else        pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o      = pipe_q[STAGES-1];
  assign q_prev_o = pipe_q[STAGES];
endmodule

// File: rtl/dbg_addr_ctr.sv
module dbg_addr_ctr #(
  parameter int unsigned AW  = 7,
  parameter int unsigned TOP = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] TOP_A = AW'(TOP);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        addr_q <= '0;
    else if (load_i)                   addr_q <= load_val_i;
    else if (step_i && addr_q < TOP_A) addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  // R4: any change that is not a load is one step up from below the ceiling
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(addr_q) && !$past(load_i)) |->
      (addr_q == $past(addr_q) + AW'(1) && $past(addr_q) < TOP_A));

  // R5: a step at or above the ceiling leaves the address unchanged
  assert_addr_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && addr_q >= TOP_A) |=> $stable(addr_q));
endmodule

// File: rtl/dbg_rd_slave.sv
module dbg_rd_slave
  import dbg_rd_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 8,
  parameter int unsigned ADDR_TOP = 31,
  parameter int unsigned SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_clk_i,
  input  logic          dbg_dat_i,
  output logic          dbg_dat_o,
  output logic          dbg_dat_oe,
  output logic [AW-1:0] reg_addr_o,
  input  logic [DW-1:0] reg_data_i
);
  localparam int unsigned HDR_BITS = AW + 1;
  localparam int unsigned UNIT_MAX = (HDR_BITS > DW) ? HDR_BITS : DW;
  localparam int unsigned CW       = $clog2(UNIT_MAX + 1);
  localparam logic [CW-1:0] HDR_END = CW'(HDR_BITS);
  localparam logic [CW-1:0] DAT_END = CW'(DW);

  // synchronized lines: index 0 = debug clock, index 1 = data
  logic [1:0] raw_w, cur_w, prv_w;
  assign raw_w = {dbg_dat_i, dbg_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    dbg_line_sync #(.STAGES(SYNC), .RST_V(1'b1)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_i      (raw_w[g]),
      .q_o      (cur_w[g]),
      .q_prev_o (prv_w[g])
    );
  end

  logic clk_s, dat_s, clk_rise, clk_fall, start_det;
  assign clk_s     = cur_w[0];
  assign dat_s     = cur_w[1];
  assign clk_rise  = cur_w[0] & ~prv_w[0];
  assign clk_fall  = ~cur_w[0] & prv_w[0];
  assign start_det = cur_w[0] & prv_w[0] & prv_w[1] & ~cur_w[1];

  dbg_phase_t    phase_q;
  logic [CW-1:0] cnt_q;
  logic [AW:0]   hdr_q;
  logic [DW-1:0] shr_q;
  logic          oe_q, dout_q;

  logic ld_addr, step_addr;
  assign ld_addr   = !start_det && phase_q == PH_HDR && clk_rise &&
                     cnt_q == HDR_END && hdr_q[0];
  assign step_addr = !start_det && phase_q == PH_DATA && clk_rise &&
                     cnt_q == DAT_END && dat_s;

  dbg_addr_ctr #(.AW(AW), .TOP(ADDR_TOP)) u_actr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_addr),
    .load_val_i (hdr_q[AW:1]),
    .step_i     (step_addr),
    .addr_o     (reg_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      shr_q   <= '0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b1;
    end else if (start_det) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_HDR: begin
          if (clk_rise) begin
            if (cnt_q < HDR_END) begin
              hdr_q <= {hdr_q[AW-1:0], dat_s};
              cnt_q <= cnt_q + CW'(1);
            end else begin
              cnt_q   <= '0;
              phase_q <= hdr_q[0] ? PH_DATA : PH_IDLE;
            end
          end
        end
        PH_DATA: begin
          if (clk_fall) begin
            if (cnt_q < DAT_END) begin
              oe_q <= 1'b1;
              if (cnt_q == '0) begin
                dout_q <= reg_data_i[DW-1];
                shr_q  <= reg_data_i << 1;
              end else begin
                dout_q <= shr_q[DW-1];
                shr_q  <= shr_q << 1;
              end
            end else begin
              oe_q <= 1'b0;
            end
          end
          if (clk_rise) begin
            if (cnt_q < DAT_END) begin
              cnt_q <= cnt_q + CW'(1);
            end else begin
              cnt_q <= '0;
              if (!dat_s) phase_q <= PH_IDLE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  assign dbg_dat_oe = oe_q;
  assign dbg_dat_o  = dout_q;

  // R3: enable may rise only after a detected falling debug-clock edge
  assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_dat_oe) |-> $past(clk_fall));

  // R3: output value holds while the debug clock stays high
  assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_s && $past(clk_s)) |-> $stable(dbg_dat_o));

  // R2: line released for the whole header
  assert_hdr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HDR) |-> !dbg_dat_oe);

  // R7: start returns to header bit zero
  assert_start_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase_q == PH_HDR && cnt_q == '0 && !dbg_dat_oe));
endmodule

// File: tb/dbg_rd_slave_bench.sv
module dbg_rd_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic dat_o, dat_oe;
  logic [6:0] raddr;
  logic [7:0] rdata;
  logic line;

  int checks = 0;
  int fails = 0;
  int oe_cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] model(input logic [6:0] a);
    return 8'((a * 29) + 7);
  endfunction

  assign rdata = model(raddr);
  assign line  = m_sda & (dat_oe ? dat_o : 1'b1);

  dbg_rd_slave u_dbg_rd_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_clk_i  (m_scl),
    .dbg_dat_i  (line),
    .dbg_dat_o  (dat_o),
    .dbg_dat_oe (dat_oe),
    .reg_addr_o (raddr),
    .reg_data_i (rdata)
  );

  always @(posedge clk) if (dat_oe) oe_cycles <= oe_cycles + 1;

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic drive_bit(input logic b, input bit chk_rel, input string req);
    m_sda = b; tick(H);
    m_scl = 1'b1; tick(H/2);
    if (chk_rel) check(dat_oe == 1'b0, req, dat_oe, 0);
    tick(H/2);
    m_scl = 1'b0;
  endtask

  task automatic send_header(input logic [6:0] a, input logic rd);
    for (int i = 6; i >= 0; i--) drive_bit(a[i], 1'b0, "");
    drive_bit(rd, 1'b0, "");
    drive_bit(1'b1, 1'b1, "R2 header separator released");
  endtask

  task automatic read_byte(output logic [7:0] v, output bit all_oe);
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H/2);
      v[i] = line;
      if (!dat_oe) all_oe = 1'b0;
      tick(H/2);
      m_scl = 1'b0;
    end
  endtask

  // R1 R3 R4 R5: full block read with model-based expectation
  task automatic read_txn(input logic [6:0] a, input int n);
    logic [6:0] ea;
    logic [7:0] got;
    bit aoe;
    ea = a;
    send_start();
    send_header(a, 1'b1);
    for (int k = 0; k < n; k++) begin
      read_byte(got, aoe);
      check(got == model(ea), "R1/R3/R4/R5 byte value", got, model(ea));
      check(aoe, "R3 driven during data bits", aoe, 1);
      drive_bit(k < n - 1, 1'b1, "R2 data separator released");
      if (ea < 7'h1F) ea = ea + 7'd1;
    end
  endtask

  // {address, byte count}
  localparam logic [11:0] VEC [6] = '{
    {7'h00, 5'd4}, {7'h05, 5'd1}, {7'h1C, 5'd6},
    {7'h1F, 5'd3}, {7'h12, 5'd2}, {7'h2A, 5'd2}
  };

  initial begin
    int snap;
    logic [7:0] got;
    bit aoe;
    tick(4);
    check(dat_oe == 1'b0, "R9 reset oe", dat_oe, 0);
    check(raddr == 7'h00, "R9 reset address", raddr, 0);
    rst_n = 1'b1;
    tick(4);

    for (int v = 0; v < 6; v++) read_txn(VEC[v][11:5], int'(VEC[v][4:0]));

    // R8: write header never drives
    snap = oe_cycles;
    send_start();
    send_header(7'h03, 1'b0);
    for (int i = 0; i < 18; i++) drive_bit(1'b1, 1'b0, "");
    check(oe_cycles == snap, "R8 write stays silent", oe_cycles - snap, 0);

    // R6: after end separator, clocks cause no drive
    read_txn(7'h04, 1);
    snap = oe_cycles;
    for (int i = 0; i < 18; i++) drive_bit(1'b1, 1'b0, "");
    check(oe_cycles == snap, "R6 idle after end", oe_cycles - snap, 0);

    // R7: restart at a data separator
    send_start();
    send_header(7'h02, 1'b1);
    read_byte(got, aoe);
    check(got == model(7'h02), "R7 pre-restart byte", got, model(7'h02));
    send_start();
    send_header(7'h09, 1'b1);
    read_byte(got, aoe);
    check(got == model(7'h09), "R7 restart at separator", got, model(7'h09));
    drive_bit(1'b0, 1'b1, "R2 data separator released");

    // R7: restart in the middle of a header
    send_start();
    for (int i = 0; i < 3; i++) drive_bit(1'b0, 1'b0, "");
    send_start();
    send_header(7'h11, 1'b1);
    read_byte(got, aoe);
    check(got == model(7'h11), "R7 restart mid-header", got, model(7'h11));
    drive_bit(1'b0, 1'b1, "R2 data separator released");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule